// File: doc/BRIEF.md
# Decode-Stage Hazard and Operand Bypass Unit

This block sits beside the decode stage of a five-stage, 32-register RISC pipeline. Each cycle it looks at the two source register indices of the instruction being decoded, called rs and rt. It compares them with the destination registers of the two older instructions still in flight, one in the execute stage and one in the memory stage. From that comparison it either raises a stall request for decode, or it corrects the operand values that are about to be latched into the decode operand register.

A static two-bit mode input chooses how dependencies are handled. In the pass mode they are ignored. In the interlock mode any dependency stalls. In the bypass mode results are forwarded, and only a value that is not ready yet causes a stall. The block has no state of its own. The stall output and the two corrected operands depend only on the current decode fields and on the stage fields supplied by the pipeline registers. The register file, the ALU and the data memory live outside this block.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A stage (execute or memory) conflicts with decode exactly when its write enable is 1, its destination index is nonzero, and that index equals the decode rs index or the decode rt index.
- R2: A destination index of 0 never causes a stall and never replaces an operand, whatever the write enable and mode.
- R3: With mode 2'b00 (pass), stall is 0 and the rs/rt outputs equal the register-file read values for every input.
- R4: With mode 2'b01 (interlock), an execute-stage conflict raises stall, and the operand outputs equal the register-file values.
- R5: With mode 2'b01 (interlock), a memory-stage conflict raises stall.
- R6: With mode 2'b10 (bypass), an execute-stage conflict whose instruction is a load (load flag 1) raises stall.
- R7: With mode 2'b10 (bypass), an execute-stage conflict from a non-load does not stall. The execute ALU result replaces the rs output when the destination matches rs, and replaces the rt output when it matches rt. Both can be replaced in the same cycle.
- R8: With mode 2'b10 (bypass), a memory-stage conflict does not stall. The memory-stage result value replaces each matching operand.
- R9: With mode 2'b10, when a non-load execute instruction and the memory instruction both match the same source, the execute ALU result wins.
- R10: When no conflict exists, stall is 0 and the outputs equal the register-file values. The unused mode 2'b11 behaves like mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Handling mode: 00 pass, 01 interlock, 10 bypass, 11 treated as pass |
| dec_rs_idx | input | 5 | rs index of the decode instruction |
| dec_rt_idx | input | 5 | rt index of the decode instruction |
| rf_rs_val | input | 32 | Register-file read value for rs |
| rf_rt_val | input | 32 | Register-file read value for rt |
| ex_we | input | 1 | Execute-stage register write enable |
| ex_dst | input | 5 | Execute-stage destination index |
| ex_is_load | input | 1 | Execute-stage instruction is a memory load |
| ex_alu_val | input | 32 | Execute-stage ALU result |
| mem_we | input | 1 | Memory-stage register write enable |
| mem_dst | input | 5 | Memory-stage destination index |
| mem_val | input | 32 | Memory-stage result (loaded data or ALU value) |
| stall | output | 1 | Hold decode this cycle |
| op_rs | output | 32 | Corrected rs operand |
| op_rt | output | 32 | Corrected rt operand |

## Verification
The immediate assertions assume that the mode input is static while a group of instructions is evaluated. They also assume that all inputs settle together, because the unit is purely combinational. The bench changes every input only just after a rising clock edge and compares outputs at the falling edge. It keeps the mode constant across each random block, and it draws destination indices from a narrow range including 0 so that conflicts, zero-register writes and overlaps between the two stages are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    HZ_PASS  = 2'b00,
    HZ_LOCK  = 2'b01,
    HZ_BYP   = 2'b10,
    HZ_RSVD  = 2'b11
  } hz_mode_e;

  localparam int NSRC = 2;  // rs, rt
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic          we,
  input  logic [AW-1:0] dst,
  input  logic [AW-1:0] src,
  output logic          hit
);
  // register 0 is never a real destination
  always_comb hit = we && (dst != '0) && (dst == src);
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import hz_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       ex_any,
  input  logic       ex_is_load,
  input  logic       mem_any,
  output logic       stall,
  output logic       ex_fwd_en,
  output logic       mem_fwd_en
);
  hz_mode_e m;
  always_comb begin
    m          = hz_mode_e'(mode);
    stall      = 1'b0;
    ex_fwd_en  = 1'b0;
    mem_fwd_en = 1'b0;
    case (m)
      HZ_LOCK: stall = ex_any || mem_any;
      HZ_BYP: begin
        stall      = ex_any && ex_is_load;
        ex_fwd_en  = !ex_is_load;
        mem_fwd_en = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rf_val,
  input  logic            ex_sel,
  input  logic [XLEN-1:0] ex_val,
  input  logic            mem_sel,
  input  logic [XLEN-1:0] mem_val,
  output logic [XLEN-1:0] op
);
  // younger (execute) result has priority
  always_comb begin
    if (ex_sel)       op = ex_val;
    else if (mem_sel) op = mem_val;
    else              op = rf_val;
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   dec_rs_idx,
  input  logic [AW-1:0]   dec_rt_idx,
  input  logic [XLEN-1:0] rf_rs_val,
  input  logic [XLEN-1:0] rf_rt_val,
  input  logic            ex_we,
  input  logic [AW-1:0]   ex_dst,
  input  logic            ex_is_load,
  input  logic [XLEN-1:0] ex_alu_val,
  input  logic            mem_we,
  input  logic [AW-1:0]   mem_dst,
  input  logic [XLEN-1:0] mem_val,
  output logic            stall,
  output logic [XLEN-1:0] op_rs,
  output logic [XLEN-1:0] op_rt
);
  logic [AW-1:0]   src_idx [NSRC];
  logic [XLEN-1:0] rf_val  [NSRC];
  logic [XLEN-1:0] op_val  [NSRC];
  logic [NSRC-1:0] ex_hit, mem_hit;
  logic            ex_fwd_en, mem_fwd_en;

  always_comb begin
    src_idx[0] = dec_rs_idx;
    src_idx[1] = dec_rt_idx;
    rf_val[0]  = rf_rs_val;
    rf_val[1]  = rf_rt_val;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_src_match #(.AW(AW)) u_ex_m (
      .we(ex_we), .dst(ex_dst), .src(src_idx[s]), .hit(ex_hit[s])
    );
    hz_src_match #(.AW(AW)) u_mem_m (
      .we(mem_we), .dst(mem_dst), .src(src_idx[s]), .hit(mem_hit[s])
    );
    hz_operand_sel #(.XLEN(XLEN)) u_sel (
      .rf_val (rf_val[s]),
      .ex_sel (ex_fwd_en && ex_hit[s]),
      .ex_val (ex_alu_val),
      .mem_sel(mem_fwd_en && mem_hit[s]),
      .mem_val(mem_val),
      .op     (op_val[s])
    );
  end

  hz_stall_ctl u_ctl (
    .mode      (mode),
    .ex_any    (|ex_hit),
    .ex_is_load(ex_is_load),
    .mem_any   (|mem_hit),
    .stall     (stall),
    .ex_fwd_en (ex_fwd_en),
    .mem_fwd_en(mem_fwd_en)
  );

  assign op_rs = op_val[0];
  assign op_rt = op_val[1];
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic [1:0]      mode,
  input logic [AW-1:0]   dec_rs_idx,
  input logic [AW-1:0]   dec_rt_idx,
  input logic [XLEN-1:0] rf_rs_val,
  input logic [XLEN-1:0] rf_rt_val,
  input logic            ex_we,
  input logic [AW-1:0]   ex_dst,
  input logic            ex_is_load,
  input logic [XLEN-1:0] ex_alu_val,
  input logic            mem_we,
  input logic [AW-1:0]   mem_dst,
  input logic            stall,
  input logic [XLEN-1:0] op_rs,
  input logic [XLEN-1:0] op_rt
);
  logic ex_on_rs, ex_on_rt;
  always_comb begin
    ex_on_rs = ex_we && ex_dst != '0 && ex_dst == dec_rs_idx;
    ex_on_rt = ex_we && ex_dst != '0 && ex_dst == dec_rt_idx;

    // R3 / R10: pass and reserved modes never intervene
    if (mode == 2'b00 || mode == 2'b11)
      p_pass_quiet_r3: assert (!stall && op_rs == rf_rs_val && op_rt == rf_rt_val);

    // R2: zero destinations leave everything untouched
    if (ex_dst == '0 && mem_dst == '0)
      p_zero_dst_r2: assert (!stall && op_rs == rf_rs_val && op_rt == rf_rt_val);

    // R4: interlock mode never substitutes operands
    if (mode == 2'b01)
      p_lock_pass_r4: assert (op_rs == rf_rs_val && op_rt == rf_rt_val);

    // R6: load in execute that feeds decode must stall in bypass mode
    if (mode == 2'b10 && ex_is_load && (ex_on_rs || ex_on_rt))
      p_load_use_r6: assert (stall);

    // R7: without an execute load, bypass mode never stalls
    if (mode == 2'b10 && !ex_is_load)
      p_byp_nostall_r7: assert (!stall);

    // R9: a non-load execute result overrides anything else on rs
    if (mode == 2'b10 && !ex_is_load && ex_on_rs)
      p_ex_prio_r9: assert (op_rs == ex_alu_val);
  end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .mode(mode), .dec_rs_idx(dec_rs_idx), .dec_rt_idx(dec_rt_idx),
  .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
  .ex_we(ex_we), .ex_dst(ex_dst), .ex_is_load(ex_is_load), .ex_alu_val(ex_alu_val),
  .mem_we(mem_we), .mem_dst(mem_dst),
  .stall(stall), .op_rs(op_rs), .op_rt(op_rt)
);

// File: tb/tb_hazard_fwd_unit.sv
`timescale 1ns/1ps
module tb_hazard_fwd_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [1:0]  mode;
  logic [4:0]  dec_rs_idx, dec_rt_idx, ex_dst, mem_dst;
  logic [31:0] rf_rs_val, rf_rt_val, ex_alu_val, mem_val;
  logic        ex_we, ex_is_load, mem_we;
  logic        stall;
  logic [31:0] op_rs, op_rt;

  hazard_fwd_unit dut (
    .mode(mode), .dec_rs_idx(dec_rs_idx), .dec_rt_idx(dec_rt_idx),
    .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
    .ex_we(ex_we), .ex_dst(ex_dst), .ex_is_load(ex_is_load), .ex_alu_val(ex_alu_val),
    .mem_we(mem_we), .mem_dst(mem_dst), .mem_val(mem_val),
    .stall(stall), .op_rs(op_rs), .op_rt(op_rt)
  );

  int nvec = 0, nbad = 0;
  bit done = 0;

  // behavioural reference, written from the requirements
  logic        e_stall;
  logic [31:0] e_rs, e_rt;
  task automatic model();
    bit ex_rs, ex_rt, m_rs, m_rt, lock, byp;
    lock  = (mode == 2'd1);
    byp   = (mode == 2'd2);
    ex_rs = ex_we  && ex_dst  != 0 && ex_dst  == dec_rs_idx;
    ex_rt = ex_we  && ex_dst  != 0 && ex_dst  == dec_rt_idx;
    m_rs  = mem_we && mem_dst != 0 && mem_dst == dec_rs_idx;
    m_rt  = mem_we && mem_dst != 0 && mem_dst == dec_rt_idx;
    e_stall = 0; e_rs = rf_rs_val; e_rt = rf_rt_val;
    if (lock && (ex_rs || ex_rt || m_rs || m_rt)) e_stall = 1;
    if (byp) begin
      if (ex_is_load && (ex_rs || ex_rt)) e_stall = 1;
      if (m_rs) e_rs = mem_val;
      if (m_rt) e_rt = mem_val;
      if (!ex_is_load && ex_rs) e_rs = ex_alu_val;
      if (!ex_is_load && ex_rt) e_rt = ex_alu_val;
    end
  endtask

  task automatic set_in(input int m, input int rs, input int rt,
                        input bit xwe, input int xd, input bit xl,
                        input bit mwe, input int md);
    mode = m[1:0]; dec_rs_idx = rs[4:0]; dec_rt_idx = rt[4:0];
    ex_we = xwe; ex_dst = xd[4:0]; ex_is_load = xl;
    mem_we = mwe; mem_dst = md[4:0];
    rf_rs_val = 32'h1111_0000 + rs; rf_rt_val = 32'h2222_0000 + rt;
    ex_alu_val = 32'hE0E0_0000 + xd; mem_val = 32'hA5A5_0000 + md;
  endtask

  task automatic check(input string tag);
    @(negedge clk);
    model();
    nvec++;
    if (stall !== e_stall || op_rs !== e_rs || op_rt !== e_rt) begin
      nbad++;
      $display("FAIL %s: stall/rs/rt got %b %h %h exp %b %h %h",
               tag, stall, op_rs, op_rt, e_stall, e_rs, e_rt);
    end
    @(posedge clk); #0.5;
  endtask

  task automatic vec(input int m, input int rs, input int rt,
                     input bit xwe, input int xd, input bit xl,
                     input bit mwe, input int md, input string tag);
    set_in(m, rs, rt, xwe, xd, xl, mwe, md);
    check(tag);
  endtask

  initial begin
    set_in(0, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #0.5;
    check("R10 idle");
    // R1: match conditions
    vec(1, 3, 4, 1, 3, 0, 0, 0, "R1 ex on rs");
    vec(1, 3, 4, 0, 3, 0, 0, 0, "R1 we low");
    vec(1, 3, 4, 1, 5, 0, 0, 0, "R1 no match");
    // R2: register 0
    vec(2, 0, 0, 1, 0, 0, 1, 0, "R2 zero dst byp");
    vec(1, 0, 0, 1, 0, 1, 1, 0, "R2 zero dst lock");
    // R3: pass mode
    vec(0, 7, 8, 1, 7, 1, 1, 8, "R3 pass ignores");
    // R4, R5: interlock
    vec(1, 9, 10, 1, 10, 0, 0, 0, "R4 ex on rt stalls");
    vec(1, 9, 10, 0, 0, 0, 1, 9, "R5 mem stalls");
    // R6: load-use
    vec(2, 6, 2, 1, 6, 1, 0, 0, "R6 load-use");
    vec(2, 6, 2, 1, 2, 1, 1, 6, "R6 load-use rt");
    // R7: back-to-back ALU
    vec(2, 5, 1, 1, 5, 0, 0, 0, "R7 fwd rs");
    vec(2, 1, 5, 1, 5, 0, 0, 0, "R7 fwd rt");
    vec(2, 5, 5, 1, 5, 0, 0, 0, "R7 fwd both");
    // R8: memory stage
    vec(2, 12, 13, 0, 0, 0, 1, 13, "R8 mem fwd rt");
    vec(2, 12, 13, 1, 4, 1, 1, 12, "R8 mem fwd with unrelated load");
    // R9: priority
    vec(2, 14, 15, 1, 14, 0, 1, 14, "R9 ex beats mem");
    vec(2, 14, 15, 1, 14, 0, 1, 15, "R9 split sources");
    // R10: reserved mode
    vec(3, 7, 8, 1, 7, 0, 1, 8, "R10 mode 3 as pass");
    vec(2, 20, 21, 1, 22, 0, 1, 23, "R10 no conflict");
    // random blocks, mode static per block
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 1500; k++) begin
        set_in(m, $urandom_range(0, 3), $urandom_range(0, 3),
               1'($urandom), $urandom_range(0, 3), 1'($urandom),
               1'($urandom), $urandom_range(0, 3));
        rf_rs_val = $urandom; rf_rt_val = $urandom;
        ex_alu_val = $urandom; mem_val = $urandom;
        check("random R1 R7 R8 R9");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule